// File: doc/BRIEF.md
# Echo-Canceller Group Power Sequencer

This block is the control logic shared by a pair of echo cancellers on a framed PCM stream. It holds a five-bit group control byte. Bit 0 turns the group on. Bit 1 picks the companding law. Bit 2 picks the coding format. Bits 3 and 4 mask the two tone-detector interrupts. The law, format and mask settings appear as level outputs that both cancellers of the group use.

While the group is off, the block acts as a bypass path. Receive samples and send samples each pass through a delay line that advances only on the frame strobe. A sample therefore appears at the output exactly two frames after it was captured.

When software writes the on bit and it goes from 0 to 1, the block starts an initialization sequence:
- It gives a one-cycle coefficient-clear pulse.
- It holds a busy flag for two frame strobes.
- It then raises a ready flag, which tells software that per-channel settings may now be written.

Clearing the on bit cancels the sequence at once and puts the group back into bypass.

Top module: `group_pwr_seq`

## Requirements
- R1: After reset the control byte reads 0x00, the group is off, and init_busy, coef_clear and ready are low.
- R2: A write with wr_en stores wr_data[4:0] into the control byte. rd_data returns that byte with bits 7:5 always 0.
- R3: Control byte bit 0 drives group_on. Bit 1 drives alaw_sel (1 = A-law, 0 = mu-law). Bit 2 drives g711_sel (1 = G.711 coding, 0 = sign-magnitude). Bit 3 drives tone_a_mask and bit 4 drives tone_b_mask.
- R4: While group_on is 0, the delay line captures rx_in and tx_in at each frame strobe. After strobe k, rx_out and tx_out show the samples captured at strobe k-2 (0 before two earlier captures). Between strobes they hold steady.
- R5: While group_on is 1, rx_out and tx_out are 0.
- R6: A write that moves bit 0 from 0 to 1 raises init_busy and produces a coef_clear pulse lasting exactly one cycle, both in the cycle after the write.
- R7: The second frame strobe seen while init_busy is high ends initialization. In the cycle after that strobe, init_busy is 0 and ready is 1. ready and init_busy are never high together.
- R8: A write that keeps bit 0 at 1 neither restarts initialization nor changes init_busy or ready.
- R9: A write that clears bit 0 drops init_busy and ready in the next cycle. The group then stays un-ready until a new 0-to-1 write and a complete initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle frame boundary strobe |
| wr_en | input | 1 | Control byte write enable |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte read value |
| rx_in | input | SAMPLE_W | Receive-side PCM sample in |
| tx_in | input | SAMPLE_W | Send-side PCM sample in |
| rx_out | output | SAMPLE_W | Receive-side bypass sample out |
| tx_out | output | SAMPLE_W | Send-side bypass sample out |
| alaw_sel | output | 1 | 1 = A-law, 0 = mu-law |
| g711_sel | output | 1 | 1 = G.711 coding, 0 = sign-magnitude |
| tone_a_mask | output | 1 | Tone detector A interrupt mask |
| tone_b_mask | output | 1 | Tone detector B interrupt mask |
| group_on | output | 1 | Group powered up |
| init_busy | output | 1 | Initialization in progress |
| coef_clear | output | 1 | One-cycle adaptive coefficient clear pulse |
| ready | output | 1 | Initialization complete |

## Verification
The hardest states to reach from the ports are the ones where a register write and a frame strobe land in the same cycle, or where the on bit is cleared between the first and second initialization strobes. A free-running frame counter places its strobes independently of the write sequence. A flat write schedule would therefore hit such cycles only by chance, so the stimulus aligns some writes to strobe edges on purpose. Other writes cancel the sequence one strobe in, and others rewrite the byte with the on bit kept at 1 during the busy window. A behavioural model with sample queues follows every cycle of this.

// File: rtl/group_pwr_seq.sv
module group_pwr_seq #(
  parameter int SAMPLE_W     = 8,
  parameter int DELAY_FRAMES = 2,
  parameter int INIT_FRAMES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  output logic [7:0]          rd_data,
  input  logic [SAMPLE_W-1:0] rx_in,
  input  logic [SAMPLE_W-1:0] tx_in,
  output logic [SAMPLE_W-1:0] rx_out,
  output logic [SAMPLE_W-1:0] tx_out,
  output logic                alaw_sel,
  output logic                g711_sel,
  output logic                tone_a_mask,
  output logic                tone_b_mask,
  output logic                group_on,
  output logic                init_busy,
  output logic                coef_clear,
  output logic                ready
);
  localparam int CTRL_W = 5;
  localparam int CNT_W  = (INIT_FRAMES > 1) ? $clog2(INIT_FRAMES) : 1;

  logic [CTRL_W-1:0]   ctrl;
  logic [CNT_W-1:0]    frame_cnt;
  logic [SAMPLE_W-1:0] rx_pipe [DELAY_FRAMES+1];
  logic [SAMPLE_W-1:0] tx_pipe [DELAY_FRAMES+1];

  wire pwr_rise = wr_en & wr_data[0] & ~ctrl[0];
  wire pwr_drop = wr_en & ~wr_data[0];

  assign rd_data     = {{(8-CTRL_W){1'b0}}, ctrl};
  assign group_on    = ctrl[0];
  assign alaw_sel    = ctrl[1];
  assign g711_sel    = ctrl[2];
  assign tone_a_mask = ctrl[3];
  assign tone_b_mask = ctrl[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      frame_cnt  <= '0;
      init_busy  <= 1'b0;
      coef_clear <= 1'b0;
      ready      <= 1'b0;
    end else begin
      coef_clear <= pwr_rise;
      if (wr_en) ctrl <= wr_data[CTRL_W-1:0];
      if (pwr_rise) begin
        init_busy <= 1'b1;
        ready     <= 1'b0;
        frame_cnt <= '0;
      end else if (pwr_drop) begin
        init_busy <= 1'b0;
        ready     <= 1'b0;
        frame_cnt <= '0;
      end else if (init_busy && frame_stb) begin
        if (frame_cnt == CNT_W'(INIT_FRAMES-1)) begin
          init_busy <= 1'b0;
          ready     <= 1'b1;
          frame_cnt <= '0;
        end else begin
          frame_cnt <= frame_cnt + 1'b1;
        end
      end
    end
  end

  generate
    for (genvar s = 0; s <= DELAY_FRAMES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rx_pipe[s] <= '0;
          tx_pipe[s] <= '0;
        end else if (frame_stb) begin
          rx_pipe[s] <= (s == 0) ? rx_in : rx_pipe[(s == 0) ? 0 : s-1];
          tx_pipe[s] <= (s == 0) ? tx_in : tx_pipe[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign rx_out = ctrl[0] ? '0 : rx_pipe[DELAY_FRAMES];
  assign tx_out = ctrl[0] ? '0 : tx_pipe[DELAY_FRAMES];
endmodule

module group_pwr_seq_chk #(
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_stb,
  input logic                wr_en,
  input logic [7:0]          rd_data,
  input logic [SAMPLE_W-1:0] rx_out,
  input logic [SAMPLE_W-1:0] tx_out,
  input logic                group_on,
  input logic                init_busy,
  input logic                coef_clear,
  input logic                ready
);
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);

  assert_bypass_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb && !wr_en && !group_on) |=> ($stable(rx_out) && $stable(tx_out)));

  assert_quiet_when_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    group_on |-> (rx_out == '0 && tx_out == '0));

  assert_clear_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    coef_clear |=> !coef_clear);

  assert_clear_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    coef_clear |-> init_busy);

  assert_busy_ready_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && init_busy));

  assert_ready_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(frame_stb) && $past(init_busy)));

  assert_off_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !group_on |-> (!ready && !init_busy));
endmodule

bind group_pwr_seq group_pwr_seq_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/tb_group_pwr_seq.sv
module tb_group_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;
  localparam int FRAME_LEN = 8;

  logic clk = 0, rst_n = 0, frame_stb = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [SW-1:0] rx_in = 0, tx_in = 0;
  logic [7:0] rd_data;
  logic [SW-1:0] rx_out, tx_out;
  logic alaw_sel, g711_sel, tone_a_mask, tone_b_mask, group_on, init_busy, coef_clear, ready;

  group_pwr_seq #(.SAMPLE_W(SW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int m_ctrl = 0, m_frames = 0;
  bit m_busy = 0, m_ready = 0, m_clr = 0;
  logic [SW-1:0] q_rx[$], q_tx[$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // free-running frame strobe and sample stimulus
  int fcnt = 0;
  bit strobe_on = 1;
  always @(negedge clk) begin
    fcnt = (fcnt + 1) % FRAME_LEN;
    frame_stb <= strobe_on && (fcnt == FRAME_LEN-1);
    rx_in <= SW'($urandom);
    tx_in <= SW'($urandom);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_busy = 0; m_ready = 0; m_clr = 0; m_frames = 0;
      q_rx.delete(); q_tx.delete();
    end else begin
      m_clr = 0;
      if (wr_en && wr_data[0] && !m_ctrl[0]) begin
        m_busy = 1; m_ready = 0; m_clr = 1; m_frames = 0;
      end else if (wr_en && !wr_data[0]) begin
        m_busy = 0; m_ready = 0; m_frames = 0;
      end else if (m_busy && frame_stb) begin
        m_frames++;
        if (m_frames == 2) begin m_busy = 0; m_ready = 1; m_frames = 0; end
      end
      if (wr_en) m_ctrl = wr_data & 8'h1F;
      if (frame_stb) begin
        q_rx.push_back(rx_in); q_tx.push_back(tx_in);
        if (q_rx.size() > 3) begin void'(q_rx.pop_front()); void'(q_tx.pop_front()); end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int erx, etx;
      erx = 0; etx = 0;
      if (!m_ctrl[0] && q_rx.size() >= 3) begin erx = q_rx[q_rx.size()-3]; etx = q_tx[q_tx.size()-3]; end
      chk("R2 rd_data", rd_data, m_ctrl);
      chk("R3 controls", {group_on, alaw_sel, g711_sel, tone_a_mask, tone_b_mask},
          {m_ctrl[0], m_ctrl[1], m_ctrl[2], m_ctrl[3], m_ctrl[4]});
      chk(m_ctrl[0] ? "R5 rx_out" : "R4 rx_out", rx_out, erx);
      chk(m_ctrl[0] ? "R5 tx_out" : "R4 tx_out", tx_out, etx);
      chk("R6 coef_clear", coef_clear, m_clr);
      chk("R7 init_busy", init_busy, m_busy);
      chk("R7 ready", ready, m_ready);
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic wait_strobes(input int n);
    for (int i = 0; i < n; i++) @(posedge clk iff frame_stb);
    @(negedge clk);
  endtask

  // write landing on the strobe cycle
  task automatic wr_on_strobe(input logic [7:0] v);
    while (fcnt != FRAME_LEN-2) @(negedge clk);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 0);
    chk("R1 init_busy", init_busy, 0);
    chk("R1 ready", ready, 0);
    chk("R1 coef_clear", coef_clear, 0);
    rst_n = 1;
    wait_strobes(5);
    // R2 unused bits
    wr(8'hE6);
    chk("R2 unused", rd_data, 8'h06);
    wait_strobes(4);
    // R6 rise
    @(negedge clk); wr_en = 1; wr_data = 8'h0B;
    @(negedge clk); wr_en = 0;
    chk("R6 pulse", coef_clear, 1);
    chk("R6 busy", init_busy, 1);
    @(negedge clk);
    chk("R6 pulse width", coef_clear, 0);
    wait_strobes(1);
    // R8 rewrite with power kept
    wr(8'h15);
    chk("R8 still busy", init_busy, 1);
    wait_strobes(1);
    chk("R7 ready", ready, 1);
    chk("R7 busy off", init_busy, 0);
    wr(8'h07);
    chk("R8 ready kept", ready, 1);
    chk("R8 no clear", coef_clear, 0);
    // R9 abort mid-init
    wr(8'h00);
    wait_strobes(3);
    wr(8'h01);
    wait_strobes(1);
    wr(8'h00);
    chk("R9 busy", init_busy, 0);
    wait_strobes(3);
    chk("R9 ready", ready, 0);
    // writes aligned to strobes
    wr_on_strobe(8'h01);
    wait_strobes(1);
    wr_on_strobe(8'h03);
    wait_strobes(2);
    chk("R7 ready aligned", ready, 1);
    wr_on_strobe(8'h00);
    wait_strobes(4);
    wr_on_strobe(8'h1F);
    wr_on_strobe(8'h00);
    wait_strobes(6);
    // long strobe gap: bypass hold
    strobe_on = 0;
    repeat (30) @(negedge clk);
    strobe_on = 1;
    wait_strobes(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule